// File: doc/BRIEF.md
# Tick-Scheduled Trigger Pulse Generator

This block issues a train of single-cycle trigger pulses at fixed points on a coarse time base that several units share. A free-running prescaler divides the local clock and marks one tick each time it wraps. After a common start event, the block counts ticks. It fires when the tick count reaches a programmed threshold, then moves that threshold forward by a programmed spacing. It stops after a programmed number of pulses.

Because every trigger is placed on an absolute tick number and not reloaded from the previous pulse, units that were loaded with the same values and started by the same edge stay in step for the whole sequence. Before the run, software loads the three values: first threshold, repeat count and spacing. Each unit then raises its ready flag. An external agent drives the shared start line high once all units report ready.

Top module: `sync_trigger_sched`

## Requirements
- R1: While `rst` is high and on the cycle after it is released, `trig_o`, `ready_o` and `done_o` are low. The prescaler and the tick count are cleared.
- R2: A `cfg_load_i` pulse is accepted when the block is idle, armed or finished. It captures first threshold, repeat count and spacing. From the next cycle, `ready_o` is 1 and `done_o` is 0.
- R3: Counting begins only on a rising edge of `start_i` (low in one sampled cycle, high in the next) while `ready_o` is 1. `ready_o` falls at that edge. A start edge while idle, and a `start_i` level that is already high when the load is accepted, have no effect.
- R4: A tick occurs every 2^PRESCALE_W clocks. The trigger for tick k is visible on `trig_o` exactly k·2^PRESCALE_W rising clock edges after the edge that accepted the start.
- R5: At each tick the tick count is first incremented and then compared for equality with the threshold. The first trigger therefore falls on tick number equal to the loaded first threshold, which must be at least 1.
- R6: After every trigger the threshold grows by the spacing. The triggers fall on ticks first + j·spacing, for j = 0 .. repeat−1.
- R7: Exactly repeat-count triggers are issued. `done_o` rises together with the last trigger, and no trigger follows while `done_o` is high.
- R8: With a repeat count of 0, the start edge moves the block directly to `done_o` = 1 and no trigger is issued.
- R9: A `cfg_load_i` pulse while counting is ignored. The running schedule keeps its captured values.
- R10: Every trigger pulse is high for exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_first_i | input | TICK_W | Tick number of the first trigger |
| cfg_repeat_i | input | CNT_W | Number of triggers to issue |
| cfg_space_i | input | TICK_W | Ticks between consecutive triggers |
| cfg_load_i | input | 1 | Capture the three configuration values |
| start_i | input | 1 | Shared start line; its rising edge begins counting |
| trig_o | output | 1 | Registered one-cycle trigger pulse |
| ready_o | output | 1 | Parameters loaded, waiting for start |
| done_o | output | 1 | Schedule complete |

## Verification
The bench aims at the exact cycle of the first trigger. A prescaler that missed its clear at start, or that compared the tick count before incrementing it, would fire one tick or part of a tick early or late. Spacing 1 gives back-to-back ticks and shows whether the threshold advances; a design that reloaded from the wrong value would skip or repeat pulses. A repeat count of zero, a load issued mid-run, a start edge while idle, and a start line already high at load time are each driven. A design that fired once on zero count, took the new values mid-run, or treated a high level as an edge would show stray pulses or a dropped ready flag.

// File: rtl/sts_pkg.sv
package sts_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2,
    ST_DONE  = 2'd3
  } sched_state_t;
endpackage

// File: rtl/sts_prescaler.sv
module sts_prescaler #(
  parameter int PRESCALE_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic tick
);
  logic [PRESCALE_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (en)    cnt_q <= cnt_q + 1'b1;
  end

  assign tick = en && (&cnt_q);

  // R4: a tick happens only after the divider has climbed through every value
  a_r4_tick_at_wrap: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt_q == '0));
endmodule

// File: rtl/sts_core.sv
module sts_core #(
  parameter int TICK_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_ok,
  input  logic              go,
  input  logic              running,
  input  logic              tick,
  input  logic [TICK_W-1:0] cfg_first,
  input  logic [CNT_W-1:0]  cfg_repeat,
  input  logic [TICK_W-1:0] cfg_space,
  output logic              trig,
  output logic              last_fire,
  output logic              rem_zero
);
  logic [TICK_W-1:0] thr_q, space_q, ticks_q;
  logic [CNT_W-1:0]  rem_q;
  logic [TICK_W-1:0] ticks_nx;
  logic              hit;

  assign ticks_nx  = ticks_q + 1'b1;
  assign hit       = tick && (ticks_nx == thr_q);
  assign last_fire = hit && (rem_q == CNT_W'(1));
  assign rem_zero  = (rem_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q   <= '0;
      space_q <= '0;
      rem_q   <= '0;
      ticks_q <= '0;
      trig    <= 1'b0;
    end else begin
      trig <= 1'b0;
      if (load_ok) begin
        thr_q   <= cfg_first;
        space_q <= cfg_space;
        rem_q   <= cfg_repeat;
      end
      if (go) begin
        ticks_q <= '0;
      end else if (tick) begin
        ticks_q <= ticks_nx;
        if (hit) begin
          trig  <= 1'b1;
          thr_q <= thr_q + space_q;
          rem_q <= rem_q - 1'b1;
        end
      end
    end
  end

  // R10: one-cycle pulse
  a_r10_trig_single: assert property (@(posedge clk) disable iff (rst)
    trig |=> !trig);
  // R9: captured spacing does not move while counting
  a_r9_params_frozen: assert property (@(posedge clk) disable iff (rst)
    (running && $past(running)) |-> $stable(space_q));
  // R7: remaining count never grows during a run
  a_r7_rem_nonincreasing: assert property (@(posedge clk) disable iff (rst)
    (running && $past(running)) |-> (rem_q <= $past(rem_q)));
endmodule

// File: rtl/sts_ctrl.sv
module sts_ctrl
  import sts_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         load_req,
  input  logic         start_in,
  input  logic         last_fire,
  input  logic         rem_zero,
  output sched_state_t state,
  output logic         load_ok,
  output logic         go
);
  logic start_q;
  logic start_rise;

  assign start_rise = start_in && !start_q;
  assign load_ok    = load_req && (state != ST_RUN);
  assign go         = (state == ST_ARMED) && !load_req && start_rise && !rem_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      start_q <= 1'b0;
    end else begin
      start_q <= start_in;
      unique case (state)
        ST_IDLE:  if (load_ok) state <= ST_ARMED;
        ST_ARMED: begin
          if (load_ok)         state <= ST_ARMED;
          else if (start_rise) state <= rem_zero ? ST_DONE : ST_RUN;
        end
        ST_RUN:   if (last_fire) state <= ST_DONE;
        ST_DONE:  if (load_ok) state <= ST_ARMED;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // R3: a run can only be entered from the armed state
  a_r3_run_from_armed: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && $past(state) != ST_RUN) |-> ($past(state) == ST_ARMED));
endmodule

// File: rtl/sync_trigger_sched.sv
module sync_trigger_sched
  import sts_pkg::*;
#(
  parameter int PRESCALE_W = 8,
  parameter int TICK_W     = 32,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TICK_W-1:0] cfg_first_i,
  input  logic [CNT_W-1:0]  cfg_repeat_i,
  input  logic [TICK_W-1:0] cfg_space_i,
  input  logic              cfg_load_i,
  input  logic              start_i,
  output logic              trig_o,
  output logic              ready_o,
  output logic              done_o
);
  sched_state_t state;
  logic load_ok, go, tick, last_fire, rem_zero, running;

  assign running = (state == ST_RUN);
  assign ready_o = (state == ST_ARMED);
  assign done_o  = (state == ST_DONE);

  sts_ctrl u_ctrl (
    .clk(clk), .rst(rst), .load_req(cfg_load_i), .start_in(start_i),
    .last_fire(last_fire), .rem_zero(rem_zero),
    .state(state), .load_ok(load_ok), .go(go)
  );

  sts_prescaler #(.PRESCALE_W(PRESCALE_W)) u_presc (
    .clk(clk), .rst(rst), .clr(go), .en(running), .tick(tick)
  );

  sts_core #(.TICK_W(TICK_W), .CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .load_ok(load_ok), .go(go), .running(running),
    .tick(tick), .cfg_first(cfg_first_i), .cfg_repeat(cfg_repeat_i),
    .cfg_space(cfg_space_i), .trig(trig_o), .last_fire(last_fire),
    .rem_zero(rem_zero)
  );

  // R4: a trigger always follows a tick by one register stage
  a_r4_trig_on_tick: assert property (@(posedge clk) disable iff (rst)
    trig_o |-> $past(tick));
  // R7: nothing fires once the schedule has been complete for a cycle
  a_r7_quiet_after_done: assert property (@(posedge clk) disable iff (rst)
    (done_o && $past(done_o)) |-> !trig_o);
  // R2: ready and done never coexist
  a_r2_ready_done_excl: assert property (@(posedge clk) disable iff (rst)
    !(ready_o && done_o));
endmodule

// File: tb/sync_trigger_sched_tb_top.sv
module sync_trigger_sched_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PW     = 4;
  localparam int TW     = 32;
  localparam int CW     = 16;
  localparam int TPER   = 1 << PW;
  localparam int WD_MAX = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [TW-1:0] cfg_first = '0;
  logic [CW-1:0] cfg_repeat = '0;
  logic [TW-1:0] cfg_space = '0;
  logic cfg_load = 1'b0;
  logic start = 1'b0;
  logic trig_o, ready_o, done_o;

  int errors = 0;
  int checks = 0;
  int trig_seen = 0;
  int cyc_count = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_trigger_sched #(.PRESCALE_W(PW), .TICK_W(TW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .cfg_first_i(cfg_first), .cfg_repeat_i(cfg_repeat),
    .cfg_space_i(cfg_space), .cfg_load_i(cfg_load), .start_i(start),
    .trig_o(trig_o), .ready_o(ready_o), .done_o(done_o)
  );

  // behavioural reference: elapsed-clock arithmetic since the start edge
  int     m_mode = 0;     // 0 idle, 1 armed, 2 running, 3 finished
  longint m_elapsed = 0;
  longint m_next = 0;
  longint m_gap = 0;
  longint m_left = 0;
  bit     m_prev_start = 0;
  bit     e_trig = 0, e_ready = 0, e_done = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_prev_start = 0; e_trig = 0;
    end else begin
      bit rise;
      rise = start && !m_prev_start;
      m_prev_start = start;
      e_trig = 0;
      if (m_mode == 2) begin
        m_elapsed++;
        if (m_elapsed % TPER == 0 && (m_elapsed / TPER) == m_next) begin
          e_trig = 1;
          m_next += m_gap;
          m_left--;
          if (m_left == 0) m_mode = 3;
        end
      end else if (cfg_load) begin
        m_next = cfg_first; m_gap = cfg_space; m_left = cfg_repeat;
        m_mode = 1;
      end else if (m_mode == 1 && rise) begin
        m_elapsed = 0;
        m_mode = (m_left == 0) ? 3 : 2;
      end
    end
    e_ready = (m_mode == 1);
    e_done  = (m_mode == 3);
  end

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    cyc_count++;
    if (!rst) begin
      check(trig_o  === e_trig,  "R4 R5 R6 R10 trig timing", trig_o, e_trig);
      check(ready_o === e_ready, "R2 R3 ready", ready_o, e_ready);
      check(done_o  === e_done,  "R7 R8 done", done_o, e_done);
      if (trig_o) trig_seen++;
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_load(input int f, input int r, input int s);
    @(negedge clk);
    cfg_first = f; cfg_repeat = r; cfg_space = s; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    wait_cyc(3);    start = 1'b0;
  endtask

  initial begin
    int base;
    // R1: reset state
    wait_cyc(3);
    check(trig_o === 0 && ready_o === 0 && done_o === 0, "R1 reset outputs",
          {trig_o, ready_o, done_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(trig_o === 0 && ready_o === 0 && done_o === 0, "R1 after release",
          {trig_o, ready_o, done_o}, 0);

    // R3: start edge while idle has no effect
    base = trig_seen;
    pulse_start();
    wait_cyc(40);
    check(trig_seen == base, "R3 idle start ignored", trig_seen - base, 0);
    check(ready_o === 0, "R3 idle stays idle", ready_o, 0);

    // R2 R5 R6 R7: ticks 3,5,7,9
    do_load(3, 4, 2);
    check(ready_o === 1 && done_o === 0, "R2 ready after load", ready_o, 1);
    base = trig_seen;
    pulse_start();
    wait_cyc(10 * TPER + 10);
    check(trig_seen - base == 4, "R6 R7 trigger count", trig_seen - base, 4);
    check(done_o === 1, "R7 done raised", done_o, 1);
    wait_cyc(50);
    check(trig_seen - base == 4, "R7 silent after done", trig_seen - base, 4);

    // R8: zero repeat count
    do_load(5, 0, 1);
    check(done_o === 0, "R2 load clears done", done_o, 0);
    base = trig_seen;
    pulse_start();
    wait_cyc(8 * TPER);
    check(trig_seen == base, "R8 no trigger", trig_seen - base, 0);
    check(done_o === 1, "R8 done at start", done_o, 1);

    // R9: mid-run load ignored; ticks 2,7,12
    do_load(2, 3, 5);
    base = trig_seen;
    pulse_start();
    wait_cyc(20);
    do_load(1, 1, 1);
    check(ready_o === 0, "R9 load mid-run no ready", ready_o, 0);
    wait_cyc(13 * TPER + 20);
    check(trig_seen - base == 3, "R9 original schedule kept", trig_seen - base, 3);

    // R3: start already high at load is not an edge; then spacing 1, ticks 1,2,3
    @(negedge clk); start = 1'b1;
    do_load(1, 3, 1);
    base = trig_seen;
    wait_cyc(3 * TPER);
    check(ready_o === 1 && trig_seen == base, "R3 level not an edge", ready_o, 1);
    @(negedge clk); start = 1'b0;
    pulse_start();
    wait_cyc(4 * TPER + 10);
    check(trig_seen - base == 3, "R6 R10 back-to-back ticks", trig_seen - base, 3);
    check(done_o === 1, "R7 done after spacing-1 run", done_o, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cyc_count > WD_MAX);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc_count, WD_MAX);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule